// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit keeps two 16-bit pointers for addressing external data and code space. A select bit in a small control register decides which pointer is active. Every pointer operation acts only on the active pointer: byte writes through the special-function-register (SFR) port, a full 16-bit load, and a single-cycle increment. The active pointer is always driven on `addr_o`, so the surrounding core can use it directly as a memory address.

The control register lives at SFR address A2h. The select bit is bit 0. Bit 2 is hard-wired to zero, and every bit without storage also reads as zero. Software can therefore flip the selection by reading the register, adding one and writing the result back. The carry out of bit 0 stops at bit 1, which reads as zero, so the wake-up flag at bit 3 and the spare flag at bit 4 keep their values.

The 16-bit load port is a valid/ready input.
- A load is accepted in any cycle where `load_valid` and `load_ready` are both high.
- `load_ready` drops only in a cycle where the SFR port writes the low or high pointer byte.
- A producer that sees `load_ready` low must keep `load_valid` and `load_data` unchanged until the transfer completes.
- All operations in a cycle use the selection as it stood before any control-register write in that same cycle.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset, both pointers read 0000h, `addr_o` is 0000h, and the control register reads 00h.
- R2: Bit 0 of the control register (SFR A2h) selects the active pointer (0 or 1). `addr_o` shows the active pointer from the cycle after the write.
- R3: A write to SFR 82h replaces the low byte of the active pointer, and a write to 83h replaces its high byte. Reads of 82h and 83h return those bytes combinationally.
- R4: An accepted load (`load_valid` and `load_ready` both high) places `load_data` in the active pointer on the next cycle. `load_ready` is low exactly in cycles with an SFR write to 82h or 83h. A load offered in such a cycle has no effect.
- R5: A pulse on `inc` adds one to the active pointer. The carry runs from the low byte into the high byte within the cycle, and FFFFh wraps to 0000h. If an accepted load and `inc` fall in the same cycle, the load wins and the increment is dropped.
- R6: If an SFR byte write to the active pointer and `inc` fall in the same cycle, only the byte write takes effect.
- R7: The inactive pointer keeps its value across every operation on the active one.
- R8: The control register reads back bit 0 (select), bit 3 (wake-up flag) and bit 4 (spare flag) as written. Bits 1, 2, 5, 6 and 7 always read 0. SFR addresses other than 82h, 83h and A2h read 00h.
- R9: Writing back the register's read value plus one toggles the select bit and leaves bits 3 and 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Combinational SFR read data |
| load_valid | input | 1 | 16-bit load offered |
| load_ready | output | 1 | Load can be accepted this cycle |
| load_data | input | 16 | Value to load into the active pointer |
| inc | input | 1 | Increment the active pointer |
| addr_o | output | 16 | Currently selected pointer |

## Verification
Byte writes are made to both pointers with different patterns (55AAh, 2211h), and the selection is then switched. This separates a correct select from one that aliases the pointers or overwrites the inactive one. Increments are run from 00FFh and FFFFh, which shows whether the carry crosses the byte boundary and whether the count wraps. Collisions between a load, a byte write and an increment in one cycle reveal the priority order and the `load_ready` back-pressure. Read-plus-one writes to the control register, with the wake-up flag set, separate a clean toggle from one that disturbs the neighbouring flags.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int SFR_AW = 8;
  localparam logic [SFR_AW-1:0] ADR_PTR_LO = 8'h82;
  localparam logic [SFR_AW-1:0] ADR_PTR_HI = 8'h83;
  localparam logic [SFR_AW-1:0] ADR_CTL    = 8'hA2;
  localparam int CTL_SEL_BIT   = 0;
  localparam int CTL_ZERO_BIT  = 2;
  localparam int CTL_WAKE_BIT  = 3;
  localparam int CTL_SPARE_BIT = 4;

  typedef enum logic [2:0] {
    PO_NONE,
    PO_WR_LO,
    PO_WR_HI,
    PO_LOAD,
    PO_INC
  } ptr_op_e;
endpackage

// File: rtl/dptr_decode.sv
module dptr_decode
  import dptr_pkg::*;
(
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              load_valid,
  input  logic              inc,
  output ptr_op_e           op,
  output logic              ctl_wr,
  output logic              load_ready
);
  logic wr_lo, wr_hi;

  assign wr_lo      = sfr_wr && (sfr_addr == ADR_PTR_LO);
  assign wr_hi      = sfr_wr && (sfr_addr == ADR_PTR_HI);
  assign ctl_wr     = sfr_wr && (sfr_addr == ADR_CTL);
  assign load_ready = !(wr_lo || wr_hi);

  // priority: byte write, then load, then increment
  always_comb begin
    if (wr_lo)                         op = PO_WR_LO;
    else if (wr_hi)                    op = PO_WR_HI;
    else if (load_valid && load_ready) op = PO_LOAD;
    else if (inc)                      op = PO_INC;
    else                               op = PO_NONE;
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int PTR_W  = 2 * BYTE_W,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ptr_op_e                  op,
  input  logic [SEL_W-1:0]         sel,
  input  logic [BYTE_W-1:0]        wbyte,
  input  logic [PTR_W-1:0]         load_data,
  output logic [NUM_PTR*PTR_W-1:0] ptr_flat
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sel == SEL_W'(g)) begin
        case (op)
          PO_WR_LO: q[BYTE_W-1:0]     <= wbyte;
          PO_WR_HI: q[PTR_W-1:BYTE_W] <= wbyte;
          PO_LOAD:  q                 <= load_data;
          PO_INC:   q                 <= q + PTR_W'(1);
          default:  ;
        endcase
      end
    end
    assign ptr_flat[g*PTR_W +: PTR_W] = q;
  end
endmodule

// File: rtl/dptr_ctl.sv
module dptr_ctl
  import dptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel_d,
  input  logic              wake_d,
  input  logic              spare_d,
  output logic [SEL_W-1:0]  sel_q,
  output logic [BYTE_W-1:0] rb
);
  logic wake_q, spare_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      wake_q  <= 1'b0;
      spare_q <= 1'b0;
    end else if (wr_en) begin
      sel_q   <= sel_d;
      wake_q  <= wake_d;
      spare_q <= spare_d;
    end
  end

  // bits without storage, including the hard-wired bit, read as zero
  always_comb begin
    rb                = '0;
    rb[SEL_W-1:0]     = sel_q;
    rb[CTL_WAKE_BIT]  = wake_q;
    rb[CTL_SPARE_BIT] = spare_q;
  end
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int PTR_W  = 2 * BYTE_W,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [BYTE_W-1:0] sfr_wdata,
  output logic [BYTE_W-1:0] sfr_rdata,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [PTR_W-1:0]  load_data,
  input  logic              inc,
  output logic [PTR_W-1:0]  addr_o
);
  ptr_op_e                  op;
  logic                     ctl_wr;
  logic [SEL_W-1:0]         sel_q;
  logic [BYTE_W-1:0]        ctl_rb;
  logic [NUM_PTR*PTR_W-1:0] ptr_flat;
  logic [PTR_W-1:0]         active;

  dptr_decode u_dec (
    .sfr_wr     (sfr_wr),
    .sfr_addr   (sfr_addr),
    .load_valid (load_valid),
    .inc        (inc),
    .op         (op),
    .ctl_wr     (ctl_wr),
    .load_ready (load_ready)
  );

  dptr_ctl #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr),
    .sel_d   (sfr_wdata[SEL_W-1:0]),
    .wake_d  (sfr_wdata[CTL_WAKE_BIT]),
    .spare_d (sfr_wdata[CTL_SPARE_BIT]),
    .sel_q   (sel_q),
    .rb      (ctl_rb)
  );

  dptr_bank #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .sel       (sel_q),
    .wbyte     (sfr_wdata),
    .load_data (load_data),
    .ptr_flat  (ptr_flat)
  );

  assign active = ptr_flat[sel_q*PTR_W +: PTR_W];
  assign addr_o = active;

  always_comb begin
    case (sfr_addr)
      ADR_PTR_LO: sfr_rdata = active[BYTE_W-1:0];
      ADR_PTR_HI: sfr_rdata = active[PTR_W-1:BYTE_W];
      ADR_CTL:    sfr_rdata = ctl_rb;
      default:    sfr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_dptr_unit_chk.sv
module dual_dptr_unit_chk
  import dptr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int PTR_W  = 2 * BYTE_W,
  localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sfr_wr,
  input logic [SFR_AW-1:0]        sfr_addr,
  input logic [BYTE_W-1:0]        sfr_wdata,
  input logic [BYTE_W-1:0]        sfr_rdata,
  input logic                     load_valid,
  input logic                     load_ready,
  input logic [PTR_W-1:0]         load_data,
  input logic                     inc,
  input logic [PTR_W-1:0]         addr_o,
  input logic [SEL_W-1:0]         sel,
  input logic [NUM_PTR*PTR_W-1:0] ptr_flat
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_hold
    assert_inactive_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != SEL_W'(g)) |=> $stable(ptr_flat[g*PTR_W +: PTR_W]));
  end

  assert_load_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready && !(sfr_wr && sfr_addr == ADR_CTL))
    |=> addr_o == $past(load_data));

  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_valid && !sfr_wr) |=> addr_o == PTR_W'($past(addr_o) + 1));

  assert_byte_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == ADR_PTR_LO && inc)
    |=> (addr_o[BYTE_W-1:0] == $past(sfr_wdata)) &&
        (addr_o[PTR_W-1:BYTE_W] == $past(addr_o[PTR_W-1:BYTE_W])));

  assert_zero_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == ADR_CTL) |-> (sfr_rdata[CTL_ZERO_BIT] == 1'b0));

  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == ADR_CTL && sfr_wdata == BYTE_W'(sfr_rdata + 1))
    |=> sel != $past(sel));
endmodule

bind dual_dptr_unit dual_dptr_unit_chk #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sfr_wr     (sfr_wr),
  .sfr_addr   (sfr_addr),
  .sfr_wdata  (sfr_wdata),
  .sfr_rdata  (sfr_rdata),
  .load_valid (load_valid),
  .load_ready (load_ready),
  .load_data  (load_data),
  .inc        (inc),
  .addr_o     (addr_o),
  .sel        (sel_q),
  .ptr_flat   (ptr_flat)
);

// File: tb/test_dual_dptr_unit.sv
module test_dual_dptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [15:0] load_data = 16'h0000;
  logic        inc = 1'b0;
  logic [15:0] addr_o;

  always #10 clk = ~clk;

  dual_dptr_unit i_dual_dptr_unit (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .inc(inc), .addr_o(addr_o)
  );

  typedef struct {
    int          kind;   // 0 addr_o, 1 sfr_rdata, 2 load_ready
    int          due;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // reference model, built from the requirements
  logic [15:0] m_ptr [2];
  logic        m_sel, m_wk, m_sp;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ctl_rb();
    return {3'b000, m_sp, m_wk, 2'b00, m_sel};
  endfunction

  task automatic push(input int kind, input int due, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.due = due; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic op(input logic wr, input logic [7:0] a, input logic [7:0] d,
                    input logic lv, input logic [15:0] ld, input logic i, input string tag);
    logic [15:0] rd_exp;
    logic        rdy;
    logic        s;
    @(posedge clk); #1;
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
    load_valid = lv; load_data = ld; inc = i;
    s = m_sel;
    case (a)
      8'h82:   rd_exp = {8'h00, m_ptr[s][7:0]};
      8'h83:   rd_exp = {8'h00, m_ptr[s][15:8]};
      8'hA2:   rd_exp = {8'h00, ctl_rb()};
      default: rd_exp = 16'h0000;
    endcase
    push(1, cyc, rd_exp, tag);
    rdy = !(wr && (a == 8'h82 || a == 8'h83));
    push(2, cyc, {15'b0, rdy}, tag);
    if (wr && a == 8'h82)      m_ptr[s][7:0]  = d;
    else if (wr && a == 8'h83) m_ptr[s][15:8] = d;
    else if (lv && rdy)        m_ptr[s]       = ld;
    else if (i)                m_ptr[s]       = m_ptr[s] + 16'd1;
    if (wr && a == 8'hA2) begin
      m_sel = d[0]; m_wk = d[3]; m_sp = d[4];
    end
    push(0, cyc + 1, m_ptr[m_sel], tag);
  endtask

  task automatic idle(input logic [7:0] a, input string tag);
    op(1'b0, a, 8'h00, 1'b0, 16'h0000, 1'b0, tag);
  endtask

  // monitor: pops expected items as they fall due
  always @(negedge clk) begin
    item_t       it;
    logic [15:0] act;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      case (it.kind)
        0:       act = addr_o;
        1:       act = {8'h00, sfr_rdata};
        default: act = {15'b0, load_ready};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ptr[0] = 16'h0000; m_ptr[1] = 16'h0000;
    m_sel = 1'b0; m_wk = 1'b0; m_sp = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle(8'hA2, "R1");
    idle(8'h82, "R1");
    idle(8'h83, "R1");
    // R3 byte writes and reads of pointer 0
    op(1, 8'h82, 8'hAA, 0, 16'h0, 0, "R3");
    op(1, 8'h83, 8'h55, 0, 16'h0, 0, "R3");
    idle(8'h82, "R3");
    idle(8'h83, "R3");
    // R2 switch to pointer 1, R7 pointer 0 untouched
    op(1, 8'hA2, 8'h01, 0, 16'h0, 0, "R2");
    op(1, 8'h82, 8'h11, 0, 16'h0, 0, "R7");
    op(1, 8'h83, 8'h22, 0, 16'h0, 0, "R7");
    op(1, 8'hA2, 8'h00, 0, 16'h0, 0, "R2");
    idle(8'h83, "R7");
    // R4 load, and load blocked by byte write
    op(0, 8'h00, 8'h00, 1, 16'h1234, 0, "R4");
    op(1, 8'h83, 8'h77, 1, 16'hBEEF, 0, "R4");
    idle(8'h82, "R4");
    // R5 increments with carry and wrap
    op(0, 8'h00, 8'h00, 1, 16'h00FF, 0, "R5");
    op(0, 8'h00, 8'h00, 0, 16'h0, 1, "R5");
    op(0, 8'h00, 8'h00, 1, 16'hFFFF, 0, "R5");
    op(0, 8'h00, 8'h00, 0, 16'h0, 1, "R5");
    op(0, 8'h00, 8'h00, 1, 16'h4000, 1, "R5");
    // R6 byte write beats increment
    op(1, 8'h83, 8'h9C, 0, 16'h0, 1, "R6");
    op(1, 8'h82, 8'h3E, 0, 16'h0, 1, "R6");
    // R7 increment on pointer 1 leaves pointer 0
    op(1, 8'hA2, 8'h01, 0, 16'h0, 0, "R7");
    op(0, 8'h00, 8'h00, 0, 16'h0, 1, "R7");
    op(1, 8'hA2, 8'h00, 0, 16'h0, 0, "R7");
    // R8 readback masking and unmapped address
    op(1, 8'hA2, 8'hFF, 0, 16'h0, 0, "R8");
    idle(8'hA2, "R8");
    op(1, 8'hA2, 8'h08, 0, 16'h0, 0, "R8");
    idle(8'hA2, "R8");
    idle(8'h80, "R8");
    // R9 read-plus-one toggles select, keeps wake flag
    op(1, 8'hA2, ctl_rb() + 8'd1, 0, 16'h0, 0, "R9");
    idle(8'hA2, "R9");
    op(1, 8'hA2, ctl_rb() + 8'd1, 0, 16'h0, 0, "R9");
    idle(8'hA2, "R9");
    idle(8'h00, "R9");
    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule